// File: doc/BRIEF.md
# ADC Scan Trigger Arbiter

This block decides when a conversion engine with two converters may begin a scan. A scan can be launched by a software start command or by a rising edge on one of two external sync inputs. Each sync input has its own arm flag. The block enforces the rules that protect a scan in progress: once a scan is running, further starts and sync edges are discarded. The only exception is a scan that has been paused at a completion boundary.

Software drives a single register-write port. A write can re-arm either sync input, issue start or stop, and set the pause and continuous-mode levels. The conversion engine reports the end of each scan on `scan_done`. The block answers with a one-cycle `start_strobe` and keeps two registered flags: `busy` and `scan_complete`. In one-shot mode, a sync input that has launched a scan is disarmed until software re-arms it. In continuous mode, scans follow one another until a stop is written.

Top module: `scan_launch_arbiter`

## Requirements
- R1: Reset is synchronous and active-high, and may come at any time, including mid-scan. On the clock after it is sampled, `busy`, `start_strobe` and `scan_complete` are 0, both sync inputs are armed, pause is 0 and the mode is one-shot.
- R2: Write-word layout (N = converter count, default 2): bit i for i < N re-arms sync i; bit N is start; bit N+1 is stop; bit N+2 is the pause level; bit N+3 is the mode level (1 = continuous). Pause and mode take the written value on every write. A start written while idle raises `start_strobe` for exactly one cycle on the clock edge that takes the write, with `busy` high in that same cycle.
- R3: Each sync input passes through a two-stage synchronizer and a rising-edge detector. An armed rising edge seen while idle gives exactly one strobe, on the third clock edge after the input goes high. Holding the input high gives no further strobes.
- R4: While a scan is running and not paused, start commands and sync edges produce no strobe. Such an edge does not consume the arm flag of its input.
- R5: In one-shot mode, a sync edge that launches a scan disarms that input only. Its later edges are ignored until a write sets its arm bit; the other input is unaffected.
- R6: In one-shot mode without pause, `scan_done` during a running scan clears `busy` and sets `scan_complete` on the next clock.
- R7: In continuous mode without pause, `scan_done` gives a new strobe on the next clock with `busy` held high. Sync arm flags are not consumed. Only a stop ends the sequence.
- R8: A stop write clears `busy` on the next clock with no strobe. Stop takes priority over a start in the same write.
- R9: With pause set, `scan_done` enters a paused state: `busy` stays 1, `scan_complete` becomes 1 and no strobe is issued. In the paused state, a start command or an armed sync edge resumes the scan with one strobe. Clearing pause resumes with one strobe on the second clock after the write.
- R10: `scan_complete` clears when a scan is launched from idle or paused. `scan_done` received while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write enable |
| wr_data | input | NCONV+4 | Control word: arm bits, start, stop, pause, mode |
| sync_in | input | NCONV | Asynchronous sync inputs, one per converter |
| scan_done | input | 1 | End-of-scan pulse from the conversion engine |
| start_strobe | output | 1 | One-cycle scan start pulse |
| busy | output | 1 | A scan is running or paused |
| scan_complete | output | 1 | Sticky flag set by a scan completion |

## Verification
A start or stop write shows its effect in the cycle right after the write's clock edge. A `scan_done` pulse updates `busy`, `scan_complete` and any restart strobe one cycle later. A sync edge reaches `start_strobe` on the third edge after the input rises, and a cleared pause resumes on the second edge. The bench drives and samples 1 ns after each rising edge. For sync stimulus it checks every intervening cycle for an absent strobe, so an early or late strobe is reported as well as a missing one. A sweep over trigger source and mode exercises launch, discard while running, completion, disarm and re-arm. Directed sequences then cover pause, stop priority and mid-scan reset.

// File: rtl/scan_arb_pkg.sv
package scan_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } scan_st_t;
endpackage

// File: rtl/scan_sync_edge.sv
module scan_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/scan_ctl_regs.sv
module scan_ctl_regs #(
  parameter int NCONV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NCONV+3:0]   wr_data,
  input  logic [NCONV-1:0]   consume,
  output logic [NCONV-1:0]   armed,
  output logic               pause_q,
  output logic               cont_q,
  output logic               start_cmd,
  output logic               stop_cmd
);
  localparam int B_START = NCONV;
  localparam int B_STOP  = NCONV + 1;
  localparam int B_PAUSE = NCONV + 2;
  localparam int B_MODE  = NCONV + 3;

  logic [NCONV-1:0] arm_set;
  assign arm_set   = wr_en ? wr_data[NCONV-1:0] : '0;
  assign start_cmd = wr_en & wr_data[B_START];
  assign stop_cmd  = wr_en & wr_data[B_STOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= '1;
      pause_q <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      armed <= (armed & ~consume) | arm_set;
      if (wr_en) begin
        pause_q <= wr_data[B_PAUSE];
        cont_q  <= wr_data[B_MODE];
      end
    end
  end
endmodule

// File: rtl/scan_ctl_fsm.sv
module scan_ctl_fsm
  import scan_arb_pkg::*;
#(
  parameter int NCONV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             pause_q,
  input  logic             cont_q,
  input  logic [NCONV-1:0] sync_rise,
  input  logic [NCONV-1:0] armed,
  input  logic             scan_done,
  output logic [NCONV-1:0] consume,
  output logic             start_strobe,
  output logic             busy,
  output logic             scan_complete,
  output scan_st_t         st
);
  scan_st_t         st_n;
  logic             strobe_n;
  logic             cmp_n;
  logic [NCONV-1:0] sync_hit;
  logic             trig;

  assign sync_hit = sync_rise & armed;
  assign trig     = start_cmd | (|sync_hit);

  always_comb begin
    st_n     = st;
    strobe_n = 1'b0;
    cmp_n    = scan_complete;
    consume  = '0;
    if (stop_cmd) begin
      st_n = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (trig) begin
            st_n     = ST_RUN;
            strobe_n = 1'b1;
            cmp_n    = 1'b0;
            consume  = sync_hit & {NCONV{~cont_q}};
          end
        end
        ST_RUN: begin
          if (scan_done) begin
            cmp_n = 1'b1;
            if (pause_q) begin
              st_n = ST_PAUSE;
            end else if (cont_q) begin
              strobe_n = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_PAUSE: begin
          if (trig || !pause_q) begin
            st_n     = ST_RUN;
            strobe_n = 1'b1;
            cmp_n    = 1'b0;
            consume  = sync_hit & {NCONV{~cont_q}};
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      start_strobe  <= 1'b0;
      busy          <= 1'b0;
      scan_complete <= 1'b0;
    end else begin
      st            <= st_n;
      start_strobe  <= strobe_n;
      busy          <= (st_n != ST_IDLE);
      scan_complete <= cmp_n;
    end
  end
endmodule

// File: rtl/scan_launch_arbiter.sv
module scan_launch_arbiter
  import scan_arb_pkg::*;
#(
  parameter int NCONV       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NCONV+3:0] wr_data,
  input  logic [NCONV-1:0] sync_in,
  input  logic             scan_done,
  output logic             start_strobe,
  output logic             busy,
  output logic             scan_complete
);
  logic [NCONV-1:0] sync_rise;
  logic [NCONV-1:0] armed;
  logic [NCONV-1:0] consume;
  logic             pause_q;
  logic             cont_q;
  logic             start_cmd;
  logic             stop_cmd;
  scan_st_t         st;

  for (genvar i = 0; i < NCONV; i++) begin : g_sync
    scan_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .din  (sync_in[i]),
      .rise (sync_rise[i])
    );
  end

  scan_ctl_regs #(.NCONV(NCONV)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .consume   (consume),
    .armed     (armed),
    .pause_q   (pause_q),
    .cont_q    (cont_q),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd)
  );

  scan_ctl_fsm #(.NCONV(NCONV)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start_cmd     (start_cmd),
    .stop_cmd      (stop_cmd),
    .pause_q       (pause_q),
    .cont_q        (cont_q),
    .sync_rise     (sync_rise),
    .armed         (armed),
    .scan_done     (scan_done),
    .consume       (consume),
    .start_strobe  (start_strobe),
    .busy          (busy),
    .scan_complete (scan_complete),
    .st            (st)
  );
endmodule

// File: rtl/scan_launch_arbiter_chk.sv
module scan_launch_arbiter_chk
  import scan_arb_pkg::*;
#(
  parameter int NCONV = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [NCONV+3:0] wr_data,
  input logic             scan_done,
  input logic             start_strobe,
  input logic             busy,
  input logic             scan_complete,
  input scan_st_t         st,
  input logic             pause_q,
  input logic             cont_q,
  input logic [NCONV-1:0] armed
);
  logic stop_w;
  assign stop_w = wr_en & wr_data[NCONV+1];

  a_r2_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    start_strobe |-> busy);

  a_r4_run_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !scan_done) |=> !start_strobe);

  a_r6_oneshot_end: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && scan_done && !pause_q && !cont_q && !stop_w)
      |=> (!busy && scan_complete && !start_strobe));

  a_r7_cont_restart: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && scan_done && !pause_q && cont_q && !stop_w)
      |=> (busy && start_strobe));

  a_r8_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> (!busy && !start_strobe));

  a_r9_pause_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && scan_done && pause_q && !stop_w)
      |=> (busy && scan_complete && !start_strobe));

  for (genvar i = 0; i < NCONV; i++) begin : g_arm
    a_r5_arm_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[i]) |=> armed[i]);
  end
endmodule

bind scan_launch_arbiter scan_launch_arbiter_chk #(.NCONV(NCONV)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .scan_done     (scan_done),
  .start_strobe  (start_strobe),
  .busy          (busy),
  .scan_complete (scan_complete),
  .st            (st),
  .pause_q       (pause_q),
  .cont_q        (cont_q),
  .armed         (armed)
);

// File: tb/scan_launch_arbiter_test.sv
module scan_launch_arbiter_test;
  localparam int NCONV = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [NCONV+3:0] wr_data = '0;
  logic [NCONV-1:0] sync_in = '0;
  logic             scan_done = 1'b0;
  logic             start_strobe;
  logic             busy;
  logic             scan_complete;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  scan_launch_arbiter #(.NCONV(NCONV)) uut (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .sync_in       (sync_in),
    .scan_done     (scan_done),
    .start_strobe  (start_strobe),
    .busy          (busy),
    .scan_complete (scan_complete)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bit layout: {mode, pause, stop, start, arm[1:0]}
  task automatic wr(input logic [1:0] arm, input logic st, input logic sp,
                    input logic pz, input logic md);
    wr_data = {md, pz, sp, st, arm};
    wr_en   = 1'b1;
    tick();
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic done_pulse();
    scan_done = 1'b1;
    tick();
    scan_done = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; sync_in = '0; scan_done = 1'b0; wr_en = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  // strobe due on the third edge after the input rises
  task automatic sync_trig(input int i, input logic exp, input string req);
    sync_in[i] = 1'b1;
    tick(); chk({req, " sync edge+1"}, start_strobe, 0);
    tick(); chk({req, " sync edge+2"}, start_strobe, 0);
    tick(); chk({req, " sync edge+3"}, start_strobe, exp);
    tick(); chk({req, " sync held"},   start_strobe, 0);
    sync_in[i] = 1'b0;
    tick(); tick(); tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 strobe after reset", start_strobe, 0);
    chk("R1 complete after reset", scan_complete, 0);

    for (int src = 0; src < 3; src++) begin
      for (int m = 0; m < 2; m++) begin
        int oth;
        oth = (src == 2) ? 0 : 1;
        do_reset();
        wr(2'b00, 0, 0, 0, m[0]);
        chk("R2 mode write no strobe", start_strobe, 0);
        if (src == 0) begin
          wr(2'b00, 1, 0, 0, m[0]);
          chk("R2 start strobe", start_strobe, 1);
          chk("R2 start busy", busy, 1);
          tick();
          chk("R2 strobe one cycle", start_strobe, 0);
        end else begin
          sync_trig(src - 1, 1, "R3 armed launch");
          chk("R3 busy after sync", busy, 1);
        end
        wr(2'b00, 1, 0, 0, m[0]);
        chk("R4 start while running", start_strobe, 0);
        sync_trig(oth, 0, "R4 sync while running");
        done_pulse();
        if (m == 0) begin
          chk("R6 busy after done", busy, 0);
          chk("R6 complete after done", scan_complete, 1);
          chk("R6 no strobe", start_strobe, 0);
          if (src != 0) sync_trig(src - 1, 0, "R5 disarmed");
          sync_trig(oth, 1, "R5 other input still armed");
          chk("R10 complete cleared on launch", scan_complete, 0);
          done_pulse();
          if (src != 0) begin
            wr(2'b01 << (src - 1), 0, 0, 0, 0);
            chk("R5 arm write no strobe", start_strobe, 0);
            sync_trig(src - 1, 1, "R5 re-armed");
            done_pulse();
          end
        end else begin
          chk("R7 restart strobe", start_strobe, 1);
          chk("R7 busy held", busy, 1);
          chk("R7 complete", scan_complete, 1);
          wr(2'b00, 0, 1, 0, 1);
          chk("R8 stop busy", busy, 0);
          chk("R8 stop no strobe", start_strobe, 0);
          if (src != 0) begin
            sync_trig(src - 1, 1, "R7 arm kept");
            wr(2'b00, 0, 1, 0, 1);
          end
        end
      end
    end

    // stop beats start
    do_reset();
    wr(2'b00, 1, 1, 0, 0);
    chk("R8 stop over start strobe", start_strobe, 0);
    chk("R8 stop over start busy", busy, 0);

    // scan_done ignored while idle
    done_pulse();
    chk("R10 done in idle", scan_complete, 0);
    chk("R10 done in idle busy", busy, 0);

    // pause behaviour
    wr(2'b00, 1, 0, 1, 0);
    chk("R9 start strobe", start_strobe, 1);
    done_pulse();
    chk("R9 paused busy", busy, 1);
    chk("R9 paused no strobe", start_strobe, 0);
    chk("R9 paused complete", scan_complete, 1);
    wr(2'b00, 1, 0, 1, 0);
    chk("R9 start resumes", start_strobe, 1);
    chk("R10 complete cleared on resume", scan_complete, 0);
    done_pulse();
    chk("R9 paused again", busy, 1);
    sync_trig(0, 1, "R9 sync resumes");
    done_pulse();
    chk("R9 paused third", start_strobe, 0);
    wr(2'b00, 0, 0, 0, 0);
    chk("R9 clear pause edge+1", start_strobe, 0);
    tick();
    chk("R9 clear pause edge+2", start_strobe, 1);
    done_pulse();
    chk("R9 unpaused done idle", busy, 0);

    // reset mid-scan
    wr(2'b00, 1, 0, 1, 0);
    done_pulse();
    chk("R1 paused before reset", busy, 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 mid-scan reset busy", busy, 0);
    chk("R1 mid-scan reset complete", scan_complete, 0);
    chk("R1 mid-scan reset strobe", start_strobe, 0);
    sync_trig(1, 1, "R1 armed after reset");
    done_pulse();
    chk("R1 one-shot after reset", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule